// File: doc/BRIEF.md
# Vector Length Control Registers

This block holds the two length settings of a parallel-execution scalar core. The first is the maximum vector length, the longest element run the core may issue. The second is the current vector length, the run length that later parallel operations use. The datapath width is 64 bits. Each length is kept minus one in a 6-bit register, so the lengths 1 to 64 fit without a seventh bit. The block takes one read or write request per cycle. It answers in the same cycle with the value for the destination register, or with a one-cycle illegal-value pulse when it refuses a write.

Writes come from one of two sources. A register-sourced write carries the true length and is range-checked: a zero, or anything above 64, is refused and no state changes. An immediate-sourced write carries the length already minus one in its low six bits, so every value is legal. A vector-length write is clamped against the maximum and returns the new clamped length. A maximum-length write behaves like an ordinary control register: it returns the previous maximum and pulls the current length down if the current length now exceeds it.

Top module: `vlen_ctrl`

## Requirements
- R1: After reset both the maximum length and the current length read back as 1.
- R2: A read (reqIsWrite=0) returns the selected true length (stored value plus one) on rdData, zero-extended to 64 bits, with rdValid high in the same cycle and illegalPulse low. reqSel=0 selects the maximum length and reqSel=1 selects the current length.
- R3: A register-sourced write (reqFromReg=1) of value 0, to either length, raises illegalPulse in that cycle and leaves both lengths unchanged.
- R4: A register-sourced write whose 64-bit value exceeds 64 (including values with any of bits 63..7 set) raises illegalPulse and leaves both lengths unchanged.
- R5: A current-length write stores the smaller of the requested length and the present maximum length.
- R6: A current-length write returns the new, clamped current length on rdData in the request cycle.
- R7: A maximum-length write stores the requested length and returns the previous maximum length on rdData in the request cycle.
- R8: When a maximum-length write sets a value below the current length, the current length becomes the new maximum at the same clock edge. A raise of the maximum leaves the current length unchanged.
- R9: An immediate-sourced write (reqFromReg=0) takes reqData[5:0] as the length minus one (0 means 1, 63 means 64), ignores reqData[63:6], and never raises illegalPulse.
- R10: illegalPulse is high only in the cycle of a refused valid request, and rdValid is low in that cycle. With reqValid low, both outputs stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqIsWrite | input | 1 | 1 = write, 0 = read |
| reqSel | input | 1 | 0 = maximum length, 1 = current length |
| reqFromReg | input | 1 | 1 = register-sourced value, 0 = immediate (length minus one) |
| reqData | input | 64 | Write value |
| rdValid | output | 1 | rdData carries a result for the destination register |
| rdData | output | 64 | Result value, zero-extended length |
| illegalPulse | output | 1 | Write refused for an illegal value |

## Verification
Both stored lengths come out at the ports through the plain reads that follow every scenario. A current length left above the maximum, or a refused write that changed state, therefore shows on the next read, one cycle after the faulty edge. A wrong return rule (old value instead of new, or an unclamped value) shows on rdData in the request cycle itself. The bench therefore walks through clamping in both directions and the range limits at 0, 64, 65 and values with high bits set. It also drives immediate encodings whose upper bits would be illegal for a register-sourced write.

// File: rtl/vlc_pkg.sv
package vlc_pkg;

  // Source of the value placed in the destination register
  typedef enum logic [1:0] {
    RET_MVL    = 2'd0,  // present maximum length (read or old value on write)
    RET_VL     = 2'd1,  // present current length (read)
    RET_VL_NEW = 2'd2   // clamped current length being written
  } retSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic    wrMvl;
    logic    wrVl;
    logic    retEn;
    retSel_e retSel;
  } vlcStrobe_t;

endpackage

// File: rtl/vlc_ctrl.sv
module vlc_ctrl
  import vlc_pkg::*;
#(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned LEN_W = $clog2(XLEN)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqIsWrite,
  input  logic             reqSel,
  input  logic             reqFromReg,
  input  logic [XLEN-1:0]  reqData,
  output vlcStrobe_t       strb,
  output logic [LEN_W-1:0] newLen,
  output logic             illegal
);

  logic regZero;
  logic regTooBig;
  logic badValue;
  logic [LEN_W-1:0] regEnc;

  // Register-sourced value range check
  assign regZero   = (reqData == '0);
  assign regTooBig = (reqData > XLEN'(XLEN));
  assign badValue  = reqFromReg && (regZero || regTooBig);

  // Encoded (minus one) length for either source
  assign regEnc = reqData[LEN_W-1:0] - LEN_W'(1);
  assign newLen = reqFromReg ? regEnc : reqData[LEN_W-1:0];

  always_comb begin
    strb    = '{wrMvl: 1'b0, wrVl: 1'b0, retEn: 1'b0, retSel: RET_MVL};
    illegal = 1'b0;
    if (reqValid) begin
      if (!reqIsWrite) begin
        strb.retEn  = 1'b1;
        strb.retSel = reqSel ? RET_VL : RET_MVL;
      end else if (badValue) begin
        illegal = 1'b1;
      end else if (!reqSel) begin
        strb.wrMvl  = 1'b1;
        strb.retEn  = 1'b1;
        strb.retSel = RET_MVL;
      end else begin
        strb.wrVl   = 1'b1;
        strb.retEn  = 1'b1;
        strb.retSel = RET_VL_NEW;
      end
    end
  end

  // R10: at most one of the state-changing or refusing actions per cycle
  p_one_action_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrMvl, strb.wrVl, illegal}));

  // R9: immediate requests are never refused
  p_imm_never_illegal_r9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqIsWrite && !reqFromReg) |-> !illegal);

endmodule

// File: rtl/vlc_dpath.sv
module vlc_dpath
  import vlc_pkg::*;
#(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned LEN_W = $clog2(XLEN)
) (
  input  logic             clk,
  input  logic             rstN,
  input  vlcStrobe_t       strb,
  input  logic [LEN_W-1:0] newLen,
  output logic             rdValid,
  output logic [XLEN-1:0]  rdData
);

  localparam int unsigned RES_W = LEN_W + 1;

  logic [LEN_W-1:0] mvlQ;
  logic [LEN_W-1:0] vlQ;
  logic [LEN_W-1:0] vlCand;
  logic [LEN_W-1:0] retEnc;
  logic [RES_W-1:0] retLen;

  // Clamp a requested current length against the present maximum
  assign vlCand = (newLen < mvlQ) ? newLen : mvlQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mvlQ <= '0;
      vlQ  <= '0;
    end else if (strb.wrMvl) begin
      mvlQ <= newLen;
      if (vlQ > newLen) vlQ <= newLen;
    end else if (strb.wrVl) begin
      vlQ <= vlCand;
    end
  end

  always_comb begin
    unique case (strb.retSel)
      RET_VL:     retEnc = vlQ;
      RET_VL_NEW: retEnc = vlCand;
      default:    retEnc = mvlQ;
    endcase
  end

  assign retLen  = {1'b0, retEnc} + RES_W'(1);
  assign rdValid = strb.retEn;
  assign rdData  = strb.retEn ? {{(XLEN-RES_W){1'b0}}, retLen} : '0;

  // R5: current length never exceeds the maximum
  p_vl_bounded_r5: assert property (@(posedge clk) disable iff (!rstN)
    vlQ <= mvlQ);

  // R7: a maximum-length write lands in state at the next edge
  p_mvl_load_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrMvl |=> (mvlQ == $past(newLen)));

  // R6: the returned length equals the length stored afterwards
  p_vl_return_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrVl |=> (({1'b0, vlQ} + RES_W'(1)) == $past(rdData[RES_W-1:0])));

endmodule

// File: rtl/vlen_ctrl.sv
module vlen_ctrl
  import vlc_pkg::*;
#(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned LEN_W = $clog2(XLEN)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  input  logic            reqIsWrite,
  input  logic            reqSel,
  input  logic            reqFromReg,
  input  logic [XLEN-1:0] reqData,
  output logic            rdValid,
  output logic [XLEN-1:0] rdData,
  output logic            illegalPulse
);

  vlcStrobe_t       strb;
  logic [LEN_W-1:0] newLen;

  vlc_ctrl #(.XLEN(XLEN), .LEN_W(LEN_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqIsWrite (reqIsWrite),
    .reqSel     (reqSel),
    .reqFromReg (reqFromReg),
    .reqData    (reqData),
    .strb       (strb),
    .newLen     (newLen),
    .illegal    (illegalPulse)
  );

  vlc_dpath #(.XLEN(XLEN), .LEN_W(LEN_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .newLen  (newLen),
    .rdValid (rdValid),
    .rdData  (rdData)
  );

  // R10: a refused request produces no result
  p_exc_no_result_r10: assert property (@(posedge clk) disable iff (!rstN)
    illegalPulse |-> !rdValid);

  // R3: refusal only comes from a valid register-sourced write
  p_exc_source_r3: assert property (@(posedge clk) disable iff (!rstN)
    illegalPulse |-> (reqValid && reqIsWrite && reqFromReg));

  // R3 / R4: a refused write leaves both lengths untouched
  p_exc_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    illegalPulse |=> ($stable(u_dp.mvlQ) && $stable(u_dp.vlQ)));

endmodule

// File: tb/vlen_ctrl_tb_top.sv
module vlen_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 64;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            reqValid = 1'b0;
  logic            reqIsWrite = 1'b0;
  logic            reqSel = 1'b0;
  logic            reqFromReg = 1'b0;
  logic [XLEN-1:0] reqData = '0;
  logic            rdValid;
  logic [XLEN-1:0] rdData;
  logic            illegalPulse;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // captured outputs of the last request
  logic            gotValid;
  logic [XLEN-1:0] gotData;
  logic            gotIll;

  always #(CLK_PERIOD/2) clk = ~clk;

  vlen_ctrl dut_i (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .reqIsWrite   (reqIsWrite),
    .reqSel       (reqSel),
    .reqFromReg   (reqFromReg),
    .reqData      (reqData),
    .rdValid      (rdValid),
    .rdData       (rdData),
    .illegalPulse (illegalPulse)
  );

  task automatic check(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Drive one request at the falling edge, sample mid-cycle, release after the rising edge
  task automatic issue(input logic isWr, input logic sel, input logic fromReg, input logic [XLEN-1:0] data);
    @(negedge clk);
    reqValid = 1'b1; reqIsWrite = isWr; reqSel = sel; reqFromReg = fromReg; reqData = data;
    #1;
    gotValid = rdValid; gotData = rdData; gotIll = illegalPulse;
    @(posedge clk);
    #1;
    reqValid = 1'b0; reqIsWrite = 1'b0; reqData = '0;
  endtask

  task automatic readLen(input logic sel, input string tag, input int exp);
    issue(1'b0, sel, 1'b0, '0);
    check({tag, " rdValid"}, 64'(gotValid), 64'd1);
    check({tag, " illegal"}, 64'(gotIll), 64'd0);
    check({tag, " data"}, gotData, 64'(exp));
  endtask

  task automatic writeOk(input logic sel, input logic fromReg, input logic [XLEN-1:0] data,
                         input string tag, input int expRet);
    issue(1'b1, sel, fromReg, data);
    check({tag, " illegal"}, 64'(gotIll), 64'd0);
    check({tag, " rdValid"}, 64'(gotValid), 64'd1);
    check({tag, " return"}, gotData, 64'(expRet));
  endtask

  task automatic writeBad(input logic sel, input logic [XLEN-1:0] data, input string tag);
    issue(1'b1, sel, 1'b1, data);
    check({tag, " illegal"}, 64'(gotIll), 64'd1);
    check({tag, " rdValid R10"}, 64'(gotValid), 64'd0);
  endtask

  task automatic t_reset();
    readLen(1'b0, "R1 mvl after reset", 1);
    readLen(1'b1, "R1 vl after reset", 1);
  endtask

  task automatic t_immediate();
    // low six bits 0x07 -> length 8, upper bits ignored
    writeOk(1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFC7, "R9 R7 imm mvl", 1);
    readLen(1'b0, "R9 mvl imm", 8);
    // imm 63 -> 64, clamped to 8
    writeOk(1'b1, 1'b0, 64'h0000_0000_0000_003F, "R9 R6 imm vl clamp", 8);
    readLen(1'b1, "R5 vl clamped", 8);
    // imm 0 -> length 1, never illegal
    writeOk(1'b1, 1'b0, 64'h8000_0000_0000_0000, "R9 imm zero", 1);
    readLen(1'b1, "R9 vl one", 1);
  endtask

  task automatic t_register();
    writeOk(1'b0, 1'b1, 64'd64, "R7 reg mvl 64", 8);
    readLen(1'b0, "R2 mvl 64", 64);
    writeOk(1'b1, 1'b1, 64'd40, "R6 reg vl 40", 40);
    readLen(1'b1, "R2 vl 40", 40);
    writeOk(1'b1, 1'b1, 64'd64, "R6 reg vl 64", 64);
    readLen(1'b1, "R5 vl 64", 64);
  endtask

  task automatic t_illegal();
    writeBad(1'b0, 64'd0, "R3 mvl zero");
    writeBad(1'b1, 64'd0, "R3 vl zero");
    writeBad(1'b1, 64'd65, "R4 vl 65");
    writeBad(1'b0, 64'd65, "R4 mvl 65");
    writeBad(1'b0, 64'h0000_0001_0000_0004, "R4 mvl high bits");
    writeBad(1'b1, 64'h0000_0000_0000_0080, "R4 vl bit7");
    readLen(1'b0, "R3 R4 mvl unchanged", 64);
    readLen(1'b1, "R3 R4 vl unchanged", 64);
  endtask

  task automatic t_clamp();
    writeOk(1'b0, 1'b1, 64'd10, "R8 R7 lower mvl", 64);
    readLen(1'b1, "R8 vl pulled down", 10);
    readLen(1'b0, "R8 mvl 10", 10);
    writeOk(1'b0, 1'b1, 64'd20, "R8 raise mvl", 10);
    readLen(1'b1, "R8 vl kept", 10);
    writeOk(1'b1, 1'b1, 64'd33, "R5 R6 vl over mvl", 20);
    readLen(1'b1, "R5 vl 20", 20);
  endtask

  task automatic t_idle();
    @(negedge clk);
    reqIsWrite = 1'b1; reqFromReg = 1'b1; reqData = '0; reqValid = 1'b0;
    #1;
    check("R10 idle illegal", 64'(illegalPulse), 64'd0);
    check("R10 idle rdValid", 64'(rdValid), 64'd0);
    @(posedge clk);
    #1;
    reqIsWrite = 1'b0; reqFromReg = 1'b0;
    readLen(1'b1, "R10 vl after idle", 20);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rstN = 1'b1;
    t_reset();
    t_immediate();
    t_register();
    t_illegal();
    t_clamp();
    t_idle();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule